// File: doc/BRIEF.md
# Two-Wire Bus Clock Phase Generator

This block turns the system clock into the timing used by a two-wire serial bus controller. A coarse 3-bit selector picks one of eight division factors, a 4-bit fine divider multiplies that by 1 to 16, and the result sets the length of a quarter of one bus bit. Every quarter ends in a one-cycle tick. A 2-bit phase index counts the quarters of a bit, and a registered clock-release level comes from it: the clock line is held low during the first half of each bit and released during the second half, which gives an exact 50% duty cycle.

A byte sequencer uses the tick and the phase index to place data changes and samples. While `run` is low the phase index stays at 0 and the clock line stays released. When stretching is allowed, a target that holds the sensed clock line low after the generator has released it freezes the whole timebase until the line goes high again. The sensed clock line is taken to be already synchronous to `clk`.

Top module: `scl_phase_gen`

## Requirements
- R1: `presc_sel` codes 0,1,2,3,4,5,6,7 select prescale factors P = 2, 4, 8, 64, 128, 1024, 2048, 4096.
- R2: With `enable` high and no stretching, `tick` pulses high for one cycle every P × (1 + `fine_div`) clock cycles. One bus bit is four such quarters, so the bit period ranges from 8 to 262144 clocks.
- R3: While `enable` is low the counters are held cleared, `tick` is 0, `phase` is 0 and `scl_release` is 1. The first tick after `enable` rises comes exactly one quarter period after the first rising edge that samples `enable` high.
- R4: A change of `presc_sel` or `fine_div` in the middle of a quarter does not alter that quarter. The new setting applies from the next quarter boundary.
- R5: While `run` is high, `phase` advances by one (modulo 4) in the same cycle as each `tick`. While `run` is low, `phase` is 0 and `scl_release` is 1.
- R6: While running, `scl_release` is 0 in phases 0 and 1 and 1 in phases 2 and 3. Without stretching, the line is released for exactly half of each bit.
- R7: With `stretch_en` high, every cycle in which `scl_release` is 1 and `scl_sense` is 0 freezes the timebase and `phase`, and suppresses `tick`. The quarter in progress is lengthened by exactly the number of such cycles.
- R8: With `stretch_en` low, `scl_sense` has no effect: quarters keep their nominal length while the line is held low.
- R9: After the synchronous reset `rst`, `tick` is 0, `phase` is 0 and `scl_release` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the timebase; low clears the counters |
| presc_sel | input | 3 | Coarse prescale select |
| fine_div | input | DIV_W (4) | Fine divider value, quarter = P × (1 + value) |
| stretch_en | input | 1 | Allow a target to stretch the clock |
| scl_sense | input | 1 | Sensed level of the bus clock line |
| run | input | 1 | Advance the bit phases; low parks at phase 0 |
| tick | output | 1 | One-cycle pulse at each quarter boundary |
| phase | output | 2 | Quarter index within the current bit |
| scl_release | output | 1 | 1 = release the clock line, 0 = pull it low |

## Verification
The properties assume that `scl_sense` is synchronous to `clk`, and that the line can only read high when the generator releases it. The bench models the bus line as the AND of `scl_release` and a target hold signal, so this assumption always holds. The bench changes `presc_sel` and `fine_div` only while `enable` is low, except in the test for R4, which changes them one cycle after a clock edge. It raises the target hold only right after a tick into phase 2. With that timing, the length of the stretch can be predicted exactly from the number of cycles the hold stays high.

// File: rtl/scl_phase_pkg.sv
package scl_phase_pkg;
  localparam int SEL_W = 3;
  localparam int PRE_W = 12;  // wide enough for a count of 4095

  typedef logic [SEL_W-1:0] presc_sel_t;

  // Last count value (factor - 1) of the coarse prescaler for each select code.
  function automatic logic [PRE_W-1:0] presc_last(input presc_sel_t sel);
    case (sel)
      3'd0:    presc_last = 12'd1;
      3'd1:    presc_last = 12'd3;
      3'd2:    presc_last = 12'd7;
      3'd3:    presc_last = 12'd63;
      3'd4:    presc_last = 12'd127;
      3'd5:    presc_last = 12'd1023;
      3'd6:    presc_last = 12'd2047;
      default: presc_last = 12'd4095;
    endcase
  endfunction
endpackage

// File: rtl/scl_quarter_timebase.sv
module scl_quarter_timebase
  import scl_phase_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             freeze,
  input  presc_sel_t       sel,
  input  logic [DIV_W-1:0] div,
  output logic             qtick
);
  presc_sel_t       sel_q;
  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_wrap;
  logic             div_wrap;

  assign pre_wrap = (pre_cnt == presc_last(sel_q));
  assign div_wrap = (div_cnt == div_q);
  assign qtick    = enable && !freeze && pre_wrap && div_wrap;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      sel_q   <= sel;
      div_q   <= div;
    end else if (!freeze) begin
      if (pre_wrap) begin
        pre_cnt <= '0;
        if (div_wrap) begin
          div_cnt <= '0;
          sel_q   <= sel;   // new settings only at a quarter boundary
          div_q   <= div;
        end else begin
          div_cnt <= div_cnt + DIV_W'(1);
        end
      end else begin
        pre_cnt <= pre_cnt + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       run,
  input  logic       qtick,
  output logic       tick,
  output logic [1:0] phase,
  output logic       scl_rel
);
  logic [1:0] phase_nxt;

  assign phase_nxt = phase + 2'd1;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      tick    <= 1'b0;
      phase   <= 2'd0;
      scl_rel <= 1'b1;
    end else begin
      tick <= qtick;
      if (!run) begin
        phase   <= 2'd0;
        scl_rel <= 1'b1;
      end else if (qtick) begin
        phase   <= phase_nxt;
        scl_rel <= phase_nxt[1];
      end else begin
        scl_rel <= phase[1];
      end
    end
  end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_phase_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [2:0]       presc_sel,
  input  logic [DIV_W-1:0] fine_div,
  input  logic             stretch_en,
  input  logic             scl_sense,
  input  logic             run,
  output logic             tick,
  output logic [1:0]       phase,
  output logic             scl_release
);
  logic qtick;
  logic stall;

  // A target stretches only after the generator has let the line go.
  assign stall = stretch_en && run && scl_release && !scl_sense;

  scl_quarter_timebase #(.DIV_W(DIV_W)) u_timebase (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .freeze (stall),
    .sel    (presc_sel),
    .div    (fine_div),
    .qtick  (qtick)
  );

  scl_phase_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .run     (run),
    .qtick   (qtick),
    .tick    (tick),
    .phase   (phase),
    .scl_rel (scl_release)
  );
endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic       run,
  input logic       stretch_en,
  input logic       scl_sense,
  input logic       tick,
  input logic [1:0] phase,
  input logic       scl_release
);
  assert_disabled_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!tick && phase == 2'd0 && scl_release));

  assert_phase_step_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && $past(run) && $past(enable) && !$past(rst)) |-> (phase == $past(phase) + 2'd1));

  assert_parked_R5: assert property (@(posedge clk) disable iff (rst)
    (!run && enable) |=> (phase == 2'd0 && scl_release));

  assert_release_half_R6: assert property (@(posedge clk) disable iff (rst)
    (run && enable) |=> (scl_release == phase[1]));

  assert_stretch_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (stretch_en && run && enable && scl_release && !scl_sense) |=> (!tick && $stable(phase)));

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (!tick && phase == 2'd0 && scl_release));
endmodule

bind scl_phase_gen scl_phase_gen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .run         (run),
  .stretch_en  (stretch_en),
  .scl_sense   (scl_sense),
  .tick        (tick),
  .phase       (phase),
  .scl_release (scl_release)
);

// File: tb/scl_phase_gen_bench.sv
module scl_phase_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic [2:0] presc_sel = 3'd0;
  logic [3:0] fine_div = 4'd0;
  logic       stretch_en = 1'b0;
  logic       run = 1'b0;
  logic       hold = 1'b0;
  logic       scl_sense;
  logic       tick;
  logic [1:0] phase;
  logic       scl_release;
  int         checks = 0;
  int         errors = 0;
  int         cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign scl_sense = scl_release && !hold;  // open-drain bus line model

  scl_phase_gen u_scl_phase_gen (
    .clk(clk), .rst(rst), .enable(enable), .presc_sel(presc_sel),
    .fine_div(fine_div), .stretch_en(stretch_en), .scl_sense(scl_sense),
    .run(run), .tick(tick), .phase(phase), .scl_release(scl_release)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected below %0d", cycles, 190000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int factor(input int sel);
    if (sel < 3)      factor = 2 << sel;
    else if (sel < 5) factor = 64 << (sel - 3);
    else              factor = 1024 << (sel - 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_tick(input int lim, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!tick && n < lim);
  endtask

  task automatic set_cfg(input int sel, input int dv);
    enable = 1'b0;
    step();
    presc_sel = 3'(sel);
    fine_div  = 4'(dv);
    step();
    enable = 1'b1;
  endtask

  initial begin
    int n;
    int q;
    int hi;
    repeat (3) step();
    chk(!tick && phase == 2'd0 && scl_release, "R9 reset state", {tick, phase, scl_release}, 1);
    rst = 1'b0;
    step();
    chk(!tick && phase == 2'd0 && scl_release, "R3 disabled idle", {tick, phase, scl_release}, 1);

    // R1/R2/R3: every coarse code with the fine divider at 0
    for (int s = 0; s < 8; s++) begin
      q = factor(s);
      set_cfg(s, 0);
      wait_tick(q + 10, n);
      chk(n == q, $sformatf("R1 R3 first quarter sel %0d", s), n, q);
      wait_tick(q + 10, n);
      chk(n == q, $sformatf("R1 R2 quarter sel %0d", s), n, q);
    end
    // R2: every fine divider value on the three fastest codes
    for (int s = 0; s < 3; s++)
      for (int d = 0; d < 16; d++) begin
        q = factor(s) * (d + 1);
        set_cfg(s, d);
        wait_tick(q + 10, n);
        chk(n == q, $sformatf("R2 R3 first quarter sel %0d div %0d", s, d), n, q);
        wait_tick(q + 10, n);
        chk(n == q, $sformatf("R2 quarter sel %0d div %0d", s, d), n, q);
      end
    // R2: slowest setting, bit = 4 * 65536 = 262144 clocks
    set_cfg(7, 15);
    wait_tick(70000, n);
    chk(n == 65536, "R2 slowest quarter", n, 65536);

    // R3: disable mid-quarter clears the count
    set_cfg(1, 2);
    repeat (5) step();
    enable = 1'b0;
    step();
    chk(!tick && phase == 2'd0, "R3 cleared on disable", tick, 0);
    enable = 1'b1;
    wait_tick(100, n);
    chk(n == 12, "R3 restart quarter", n, 12);

    // R4: change mid-quarter, old length then new length
    set_cfg(0, 3);
    wait_tick(100, n);
    repeat (3) step();
    fine_div = 4'd0;
    wait_tick(100, n);
    chk(n + 3 == 8, "R4 current quarter keeps old setting", n + 3, 8);
    wait_tick(100, n);
    chk(n == 2, "R4 next quarter uses new setting", n, 2);

    // R5/R6: phase sequence and line level while running
    run = 1'b1;
    set_cfg(0, 1);
    for (int k = 0; k < 8; k++) begin
      wait_tick(100, n);
      chk(phase == 2'((k + 1) % 4), "R5 phase step", phase, (k + 1) % 4);
      chk(scl_release == phase[1], "R6 release in phases 2 and 3", scl_release, phase[1]);
    end
    // R6: duty cycle over one bit (Q = 4)
    do wait_tick(100, n); while (phase != 2'd0);
    hi = 0;
    for (int c = 0; c < 16; c++) begin
      step();
      if (scl_release) hi++;
    end
    chk(hi == 8, "R6 half of the bit released", hi, 8);

    // R7: stretch lengthens the quarter by the hold cycles
    stretch_en = 1'b1;
    do wait_tick(100, n); while (phase != 2'd2);
    hold = 1'b1;
    n = 0;
    do begin
      step();
      n++;
      if (n == 3) chk(phase == 2'd2 && !tick, "R7 frozen while held", phase, 2);
      if (n == 5) hold = 1'b0;
    end while (!tick && n < 100);
    chk(n == 9, "R7 stretched quarter", n, 9);
    chk(phase == 2'd3, "R7 phase after stretch", phase, 3);

    // R8: stretch disabled ignores the held line
    stretch_en = 1'b0;
    do wait_tick(100, n); while (phase != 2'd2);
    hold = 1'b1;
    wait_tick(100, n);
    hold = 1'b0;
    chk(n == 4, "R8 quarter ignores sensed line", n, 4);
    chk(phase == 2'd3, "R8 phase advanced", phase, 3);

    // R5: run low parks the phase while ticks continue
    run = 1'b0;
    for (int k = 0; k < 3; k++) begin
      wait_tick(100, n);
      chk(n <= 4 && phase == 2'd0 && scl_release, "R5 parked while not running", phase, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule